// File: doc/BRIEF.md
# Supply-Loss Protection Sequencer

This block turns two comparator flags into the control signals that keep a battery-backed memory safe while its main supply comes and goes. The first flag says the supply has dropped below the level at which the memory must stop accepting bus cycles. The second flag says the supply has dropped far enough that the battery must take over. Both flags arrive asynchronously and pass through a two-stage synchroniser. All delays are counted in clock cycles of the block's own clock.

When the supply sags, an active-low interrupt warns the host at once. For a set number of cycles, while the interrupt is pending, bus accesses still pass, so the host can finish its work. After that the memory is deselected: writes are blocked and the data bus is released. A write that is cut off at this point can damage only the location it addresses. While deselected, the battery path follows the switchover flag. When the supply comes back, the block enters a recovery interval. The interrupt clears partway through that interval, and write protection stays on until the interval ends. A sag that clears during the warning window cancels the sequence and never deselects the memory.

The host issues its own write and read requests. The block passes them on to the memory, registered, only while the memory is not deselected.

Top module: `pwrfail_seq`

## Requirements
- R1: After synchronous reset, irq_n_o=1, wprot_o=0, batt_sel_o=0, mem_we_o=0 and dq_oe_o=0.
- R2: When vlow_pfd_i rises (set before clock edge k), irq_n_o goes low after edge k+2: two synchroniser stages plus the output register. Bus writes still pass while the interrupt is pending.
- R3: If vlow_pfd_i stays high, wprot_o rises exactly WARN_CYC cycles after irq_n_o fell.
- R4: While wprot_o=1, mem_we_o and dq_oe_o stay 0 whatever bus_we_i and bus_re_i do. Otherwise, one cycle after the inputs, mem_we_o=bus_we_i and dq_oe_o=bus_re_i AND NOT bus_we_i.
- R5: If vlow_pfd_i falls during the warning window, irq_n_o returns to 1 after edge k+2 of that fall, and wprot_o never rises.
- R6: While deselected, batt_sel_o rises after edge k+2 of vlow_sw_i rising and falls after edge k+2 of it falling. wprot_o stays 1 throughout.
- R7: Once vlow_pfd_i falls while deselected, recovery begins at edge k+2. irq_n_o returns to 1 exactly INT_REL_CYC cycles after recovery begins (1 ≤ INT_REL_CYC < REC_CYC).
- R8: wprot_o falls exactly REC_CYC cycles after recovery begins, and never while irq_n_o=0.
- R9: If vlow_pfd_i rises again during recovery, wprot_o stays 1 without a gap, and irq_n_o is low after edge k+2.
- R10: vlow_sw_i has no effect outside the deselected state: batt_sel_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| vlow_pfd_i | input | 1 | Async flag: supply below the deselect threshold |
| vlow_sw_i | input | 1 | Async flag: supply below the battery switchover level |
| bus_we_i | input | 1 | Host write request |
| bus_re_i | input | 1 | Host read request |
| irq_n_o | output | 1 | Active-low power-fail interrupt |
| wprot_o | output | 1 | Deselect / write protect |
| batt_sel_o | output | 1 | Battery path select |
| mem_we_o | output | 1 | Gated write strobe to the memory |
| dq_oe_o | output | 1 | Gated data output enable |

## Verification
The bench measures the exact cycle on which the interrupt falls, deselect rises and each recovery milestone is reached. A design that is off by one in the synchroniser or the warning count would release or protect a cycle early or late. It forces a sag that clears inside the warning window, where a design that ignores the abort would deselect a live supply. It also forces a second sag during recovery, where a design that passes through the idle state would briefly drop write protection. Writes and reads are driven while protected, and the switchover flag is raised while the supply is healthy, to catch leaking strobes and a battery path that engages without deselect.

// File: rtl/pwrfail_pkg.sv
package pwrfail_pkg;

  typedef enum logic [2:0] {
    PF_NORMAL = 3'd0,
    PF_WARN   = 3'd1,
    PF_DESEL  = 3'd2,
    PF_BATT   = 3'd3,
    PF_RECOV  = 3'd4
  } pf_state_t;

  typedef struct packed {
    logic irq_n;
    logic wprot;
    logic batt;
    logic we;
    logic oe;
  } pf_out_t;

  localparam pf_out_t PF_OUT_RESET = '{irq_n: 1'b1, wprot: 1'b0, batt: 1'b0, we: 1'b0, oe: 1'b0};

endpackage

// File: rtl/pwrfail_sync.sv
module pwrfail_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/pwrfail_timer.sv
module pwrfail_timer #(
  parameter int          CNT_W   = 8,
  parameter int unsigned CNT_TOP = 200
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d
);

  localparam logic [CNT_W-1:0] TOP = CNT_W'(CNT_TOP);

  always_comb begin
    if (clr)               cnt_d = '0;
    else if (cnt_q == TOP) cnt_d = cnt_q;
    else                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

endmodule

// File: rtl/pwrfail_fsm.sv
module pwrfail_fsm
  import pwrfail_pkg::*;
#(
  parameter int WARN_CYC    = 16,
  parameter int INT_REL_CYC = 40,
  parameter int REC_CYC     = 100,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fail_s,
  input  logic             swo_s,
  input  logic             bus_we_i,
  input  logic             bus_re_i,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [CNT_W-1:0] cnt_d,
  output logic             cnt_clr,
  output pf_out_t          out_q
);

  localparam logic [CNT_W-1:0] WARN_LAST = CNT_W'(WARN_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LAST  = CNT_W'(REC_CYC - 1);
  localparam logic [CNT_W-1:0] REL_TH    = CNT_W'(INT_REL_CYC);

  pf_state_t state_q, state_d;
  pf_out_t   out_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PF_NORMAL: if (fail_s) state_d = PF_WARN;
      PF_WARN: begin
        if (!fail_s)                 state_d = PF_NORMAL;
        else if (cnt_q == WARN_LAST) state_d = PF_DESEL;
      end
      PF_DESEL: begin
        if (swo_s)        state_d = PF_BATT;
        else if (!fail_s) state_d = PF_RECOV;
      end
      PF_BATT: if (!swo_s) state_d = PF_DESEL;
      PF_RECOV: begin
        if (fail_s)                 state_d = PF_DESEL;
        else if (cnt_q == REC_LAST) state_d = PF_NORMAL;
      end
      default: state_d = PF_NORMAL;
    endcase
  end

  assign cnt_clr = (state_d != state_q);

  always_comb begin
    out_d.wprot = (state_d == PF_DESEL) || (state_d == PF_BATT) || (state_d == PF_RECOV);
    out_d.batt  = (state_d == PF_BATT);
    if (state_d == PF_RECOV) out_d.irq_n = (cnt_d >= REL_TH);
    else                     out_d.irq_n = (state_d == PF_NORMAL);
    out_d.we = bus_we_i && !out_d.wprot;
    out_d.oe = bus_re_i && !bus_we_i && !out_d.wprot;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PF_NORMAL;
      out_q   <= PF_OUT_RESET;
    end else begin
      state_q <= state_d;
      out_q   <= out_d;
    end
  end

endmodule

// File: rtl/pwrfail_seq.sv
module pwrfail_seq
  import pwrfail_pkg::*;
#(
  parameter int WARN_CYC    = 16,
  parameter int INT_REL_CYC = 40,
  parameter int REC_CYC     = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic vlow_pfd_i,
  input  logic vlow_sw_i,
  input  logic bus_we_i,
  input  logic bus_re_i,
  output logic irq_n_o,
  output logic wprot_o,
  output logic batt_sel_o,
  output logic mem_we_o,
  output logic dq_oe_o
);

  localparam int CNT_MAX = (WARN_CYC > REC_CYC) ? WARN_CYC : REC_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [1:0]       flags_s;
  logic             cnt_clr;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  pf_out_t          outs;

  pwrfail_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({vlow_sw_i, vlow_pfd_i}),
    .q   (flags_s)
  );

  pwrfail_timer #(.CNT_W(CNT_W), .CNT_TOP(CNT_MAX)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clr   (cnt_clr),
    .cnt_q (cnt_q),
    .cnt_d (cnt_d)
  );

  pwrfail_fsm #(
    .WARN_CYC    (WARN_CYC),
    .INT_REL_CYC (INT_REL_CYC),
    .REC_CYC     (REC_CYC),
    .CNT_W       (CNT_W)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .fail_s   (flags_s[0]),
    .swo_s    (flags_s[1]),
    .bus_we_i (bus_we_i),
    .bus_re_i (bus_re_i),
    .cnt_q    (cnt_q),
    .cnt_d    (cnt_d),
    .cnt_clr  (cnt_clr),
    .out_q    (outs)
  );

  assign irq_n_o    = outs.irq_n;
  assign wprot_o    = outs.wprot;
  assign batt_sel_o = outs.batt;
  assign mem_we_o   = outs.we;
  assign dq_oe_o    = outs.oe;

endmodule

// File: rtl/pwrfail_seq_chk.sv
module pwrfail_seq_chk (
  input logic clk,
  input logic rst,
  input logic irq_n_o,
  input logic wprot_o,
  input logic batt_sel_o,
  input logic mem_we_o,
  input logic dq_oe_o
);

  // R2 / R3: protection only ever follows a pending interrupt
  a_r3_protect_after_irq: assert property (@(posedge clk) disable iff (rst)
    $rose(wprot_o) |-> (!irq_n_o && $past(!irq_n_o)));

  // R4: no strobe leaks while protected
  a_r4_gate_when_protected: assert property (@(posedge clk) disable iff (rst)
    wprot_o |-> (!mem_we_o && !dq_oe_o));

  // R4: write and drive never together
  a_r4_we_oe_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(mem_we_o && dq_oe_o));

  // R6: battery path only while deselected
  a_r6_batt_needs_protect: assert property (@(posedge clk) disable iff (rst)
    batt_sel_o |-> wprot_o);

  // R6 / R10: battery engages only from an already protected state
  a_r10_batt_entry: assert property (@(posedge clk) disable iff (rst)
    $rose(batt_sel_o) |-> $past(wprot_o));

  // R8: protection lifts only after the interrupt cleared
  a_r8_release_order: assert property (@(posedge clk) disable iff (rst)
    $fell(wprot_o) |-> irq_n_o);

endmodule

bind pwrfail_seq pwrfail_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .irq_n_o    (irq_n_o),
  .wprot_o    (wprot_o),
  .batt_sel_o (batt_sel_o),
  .mem_we_o   (mem_we_o),
  .dq_oe_o    (dq_oe_o)
);

// File: tb/pwrfail_seq_tb.sv
module pwrfail_seq_tb;

  localparam int WARN_CYC    = 16;
  localparam int INT_REL_CYC = 40;
  localparam int REC_CYC     = 100;
  localparam int WDOG_LIMIT  = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vlow_pfd_i = 1'b0, vlow_sw_i = 1'b0, bus_we_i = 1'b0, bus_re_i = 1'b0;
  logic irq_n_o, wprot_o, batt_sel_o, mem_we_o, dq_oe_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwrfail_seq #(
    .WARN_CYC(WARN_CYC), .INT_REL_CYC(INT_REL_CYC), .REC_CYC(REC_CYC), .SYNC_STAGES(2)
  ) u_dut (
    .clk(clk), .rst(rst), .vlow_pfd_i(vlow_pfd_i), .vlow_sw_i(vlow_sw_i),
    .bus_we_i(bus_we_i), .bus_re_i(bus_re_i), .irq_n_o(irq_n_o), .wprot_o(wprot_o),
    .batt_sel_o(batt_sel_o), .mem_we_o(mem_we_o), .dq_oe_o(dq_oe_o)
  );

  task automatic check(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // behavioural reference: mode 0 idle, 1 warning, 2 cut off, 3 on battery, 4 recovering
  int m_mode = 0, m_age = 0, nm;
  logic qp[$] = '{1'b0, 1'b0};
  logic qs[$] = '{1'b0, 1'b0};
  logic e_irq = 1'b1, e_wp = 1'b0, e_bt = 1'b0, e_we = 1'b0, e_oe = 1'b0;
  logic p, s;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_mode = 0; m_age = 0;
      qp = '{1'b0, 1'b0}; qs = '{1'b0, 1'b0};
      e_irq = 1'b1; e_wp = 1'b0; e_bt = 1'b0; e_we = 1'b0; e_oe = 1'b0;
    end else begin
      p = qp[1]; s = qs[1];
      nm = m_mode;
      if (m_mode == 0) begin
        if (p) nm = 1;
      end else if (m_mode == 1) begin
        if (!p) nm = 0;
        else if (m_age + 1 == WARN_CYC) nm = 2;
      end else if (m_mode == 2) begin
        if (s) nm = 3;
        else if (!p) nm = 4;
      end else if (m_mode == 3) begin
        if (!s) nm = 2;
      end else begin
        if (p) nm = 2;
        else if (m_age + 1 == REC_CYC) nm = 0;
      end
      m_age  = (nm != m_mode) ? 0 : m_age + 1;
      m_mode = nm;
      e_wp  = (m_mode >= 2);
      e_bt  = (m_mode == 3);
      e_irq = (m_mode == 0) || (m_mode == 4 && m_age >= INT_REL_CYC);
      e_we  = bus_we_i && !e_wp;
      e_oe  = bus_re_i && !bus_we_i && !e_wp;
      void'(qp.pop_back()); qp.push_front(vlow_pfd_i);
      void'(qs.pop_back()); qs.push_front(vlow_sw_i);
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R2/R5/R7/R9 model irq_n", irq_n_o, e_irq);
      check("R3/R8 model wprot", wprot_o, e_wp);
      check("R6/R10 model batt_sel", batt_sel_o, e_bt);
      check("R4 model mem_we", mem_we_o, e_we);
      check("R4 model dq_oe", dq_oe_o, e_oe);
    end
  end

  always @(posedge clk) begin
    if (!done && cycles >= WDOG_LIMIT) begin
      errors++;
      $display("FAIL R1 watchdog actual=%0d expected<%0d", cycles, WDOG_LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(4);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq_n", irq_n_o, 1'b1);
    check("R1 wprot", wprot_o, 1'b0);
    check("R1 batt", batt_sel_o, 1'b0);
    check("R1 we", mem_we_o, 1'b0);
    check("R1 oe", dq_oe_o, 1'b0);

    // R4 normal pass-through
    bus_we_i = 1'b1; tick(1);
    check("R4 write passes", mem_we_o, 1'b1);
    bus_we_i = 1'b0; bus_re_i = 1'b1; tick(1);
    check("R4 read drives", dq_oe_o, 1'b1);
    bus_re_i = 1'b0;

    // R10 switchover flag ignored while healthy
    vlow_sw_i = 1'b1; tick(6);
    check("R10 batt idle", batt_sel_o, 1'b0);
    vlow_sw_i = 1'b0; tick(3);

    // R5 sag cleared inside the warning window
    vlow_pfd_i = 1'b1; tick(3);
    check("R5 irq on sag", irq_n_o, 1'b0);
    vlow_pfd_i = 1'b0; tick(3);
    check("R5 irq cleared", irq_n_o, 1'b1);
    for (int i = 0; i < WARN_CYC + 4; i++) begin
      tick(1);
      check("R5 no protect", wprot_o, 1'b0);
    end

    // R2/R3 full failure with a write in flight
    bus_we_i = 1'b1; vlow_pfd_i = 1'b1; tick(2);
    check("R2 irq not yet", irq_n_o, 1'b1);
    tick(1);
    check("R2 irq low", irq_n_o, 1'b0);
    check("R2 write still passes", mem_we_o, 1'b1);
    tick(WARN_CYC - 1);
    check("R3 protect not yet", wprot_o, 1'b0);
    tick(1);
    check("R3 protect on", wprot_o, 1'b1);
    check("R4 write blocked", mem_we_o, 1'b0);
    bus_we_i = 1'b0; bus_re_i = 1'b1; tick(1);
    check("R4 read blocked", dq_oe_o, 1'b0);
    bus_re_i = 1'b0;

    // R6 battery path
    vlow_sw_i = 1'b1; tick(2);
    check("R6 batt not yet", batt_sel_o, 1'b0);
    tick(1);
    check("R6 batt on", batt_sel_o, 1'b1);
    bus_we_i = 1'b1; tick(1);
    check("R4 write blocked on battery", mem_we_o, 1'b0);
    bus_we_i = 1'b0;
    vlow_sw_i = 1'b0; tick(3);
    check("R6 batt off", batt_sel_o, 1'b0);
    check("R6 still protected", wprot_o, 1'b1);

    // R7/R8 recovery
    vlow_pfd_i = 1'b0; tick(3);
    check("R7 irq held at entry", irq_n_o, 1'b0);
    tick(INT_REL_CYC - 1);
    check("R7 irq not yet", irq_n_o, 1'b0);
    tick(1);
    check("R7 irq released", irq_n_o, 1'b1);
    tick(REC_CYC - INT_REL_CYC - 1);
    check("R8 protect held", wprot_o, 1'b1);
    tick(1);
    check("R8 protect released", wprot_o, 1'b0);

    // R9 second sag during recovery
    vlow_pfd_i = 1'b1; tick(3 + WARN_CYC);
    check("R9 deselected", wprot_o, 1'b1);
    vlow_pfd_i = 1'b0; tick(3 + INT_REL_CYC + 2);
    check("R9 irq released", irq_n_o, 1'b1);
    vlow_pfd_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick(1);
      check("R9 protect unbroken", wprot_o, 1'b1);
    end
    check("R9 irq again", irq_n_o, 1'b0);
    vlow_pfd_i = 1'b0; tick(3 + REC_CYC + 2);
    check("R8 final release", wprot_o, 1'b0);
    check("R7 final irq", irq_n_o, 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule